// File: doc/BRIEF.md
# Circuit Path Setup Controller

This block runs the handshake that reserves and releases a circuit in a hybrid network. In that network a packet-switched electrical control network sets up an end-to-end path, and bulk data then crosses a bufferless data path. One instance holds both ends of a node. The source side turns a send request into a configuration packet that carries the destination address. It then waits for a one-clock acknowledge that comes back over the reserved data path. Once the acknowledge arrives, it gates the payload words out for the requested length and finally emits a release packet that tears the path down. The destination side answers a configuration packet with the acknowledge pulse, holds the circuit for that source, and frees it when that same source releases.

The data path delivers words in order and has no storage, so the controller only has to decide when payload may flow. It does not touch the data itself. The control network can stall a packet on its way out, which this block sees as the ready input staying low. A programmable wait limit turns a lost acknowledge into a release and a failure report, so a path that was partly reserved is never left behind.

Top module: `circuit_link_ctrl`

## Requirements
- R1: After reset the source side is idle: busy, ctl_out_valid, data_en, data_last, done_pulse and fail_pulse are 0. The destination side holds no circuit: dst_held and ack_out are 0.
- R2: A request accepted while idle raises busy and ctl_out_valid on the next clock edge. The packet kind is 0 (configuration) and ctl_out_dst equals the requested address. The packet stays offered, unchanged, until a cycle in which ctl_out_ready is 1.
- R3: busy stays 1 from acceptance until the release packet is taken. A request presented while busy is refused: it starts nothing, and the destination address used for the release is still the original one.
- R4: ack_in is acted on only while waiting after the configuration packet was taken. When it is seen there, data_en is 1 for exactly req_len consecutive cycles, starting with the edge that samples the acknowledge. data_last is 1 only with the final word. An acknowledge seen while payload flows has no effect on the word count.
- R5: A request length of 0 sends no payload. An acknowledge moves the source straight to the release packet.
- R6: After the final word the source offers a release packet of kind 1 with the same destination address, and data_en is 0 while any packet is offered. When the release is taken, busy falls and done_pulse is 1 for one cycle.
- R7: If no acknowledge arrives, the source offers the release packet exactly max(timeout_cycles,1) cycles after the configuration packet was taken. When the release is taken, fail_pulse is 1 for one cycle instead of done_pulse.
- R8: An acknowledge that arrives in the same cycle the wait limit expires wins. Payload is sent and the transfer ends with done_pulse.
- R9: A configuration packet (ctl_in_kind 0) that arrives while the destination is free sets dst_held and records ctl_in_src in dst_peer. It makes ack_out 1 for exactly one cycle, on the next edge.
- R10: A configuration packet that arrives while the destination holds a circuit is ignored: no ack_out, and dst_peer is unchanged.
- R11: A release packet (ctl_in_kind 1) clears dst_held only if ctl_in_src equals dst_peer. Any other release leaves the circuit held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Send request strobe |
| req_dst | input | ADDR_W | Destination address of the request |
| req_len | input | LEN_W | Payload length in words |
| timeout_cycles | input | TO_W | Acknowledge wait limit in cycles |
| busy | output | 1 | A source circuit is being set up or held |
| done_pulse | output | 1 | Transfer finished and path released |
| fail_pulse | output | 1 | Setup timed out and path released |
| ctl_out_valid | output | 1 | Outgoing control packet offered |
| ctl_out_ready | input | 1 | Control network takes the offered packet |
| ctl_out_kind | output | 1 | 0 configuration, 1 release |
| ctl_out_dst | output | ADDR_W | Destination address of the packet |
| ctl_out_src | output | ADDR_W | This node's address |
| ack_in | input | 1 | Acknowledge pulse from the far end over the data path |
| data_en | output | 1 | Payload word may be sent this cycle |
| data_last | output | 1 | Current payload word is the last |
| ctl_in_valid | input | 1 | Incoming control packet for this node |
| ctl_in_kind | input | 1 | 0 configuration, 1 release |
| ctl_in_src | input | ADDR_W | Source address of the incoming packet |
| ack_out | output | 1 | One-cycle acknowledge sent back to the source |
| dst_held | output | 1 | Destination circuit reserved |
| dst_peer | output | ADDR_W | Source that holds the destination circuit |

## Verification
The acknowledge and the expiry of the wait limit can fall on the same edge. The bench provokes this by counting the cycles after the configuration packet is taken and raising the acknowledge in exactly the cycle whose closing edge would otherwise expire the limit, for several limit values. Each such run passes only if the payload count equals the request length and the transfer ends with done_pulse, not fail_pulse. The same runs, with the acknowledge withheld, confirm that the release packet appears after the expected count.

// File: rtl/cls_pkg.sv
package cls_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_CFG  = 3'd1,
    S_WAIT = 3'd2,
    S_XFER = 3'd3,
    S_REL  = 3'd4
  } src_state_t;

  typedef enum logic {
    PKT_CFG = 1'b0,
    PKT_REL = 1'b1
  } pkt_kind_t;

endpackage

// File: rtl/cls_wait_timer.sv
module cls_wait_timer #(
  parameter int TO_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);
  localparam int CW = TO_W + 1;

  logic [TO_W-1:0] cnt_q;
  logic [CW-1:0]   cnt_next_w;

  assign cnt_next_w = {1'b0, cnt_q} + CW'(1);
  assign expired    = run && (cnt_next_w >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + TO_W'(1);
  end

  // R7: the count never passes the limit while waiting
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
    run && (limit != '0) |-> (cnt_q < limit));

endmodule

// File: rtl/cls_src_fsm.sv
module cls_src_fsm
  import cls_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LEN_W  = 8,
  parameter int TO_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_dst,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [TO_W-1:0]   timeout_cycles,
  input  logic              out_ready,
  input  logic              ack_in,
  output logic              busy,
  output logic              done_pulse,
  output logic              fail_pulse,
  output logic              out_valid,
  output logic              out_kind,
  output logic [ADDR_W-1:0] out_dst,
  output logic              data_en,
  output logic              data_last
);
  src_state_t        st_q, st_n;
  logic [ADDR_W-1:0] dst_q;
  logic [LEN_W-1:0]  len_q, rem_q, rem_n;
  logic              timed_out_q;
  logic              expired;
  logic              busy_q, valid_q, kind_q, en_q, last_q, done_q, fail_q;

  cls_wait_timer #(.TO_W(TO_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (st_q == S_WAIT),
    .limit   (timeout_cycles),
    .expired (expired)
  );

  always_comb begin
    st_n  = st_q;
    rem_n = rem_q;
    unique case (st_q)
      S_IDLE: if (req_valid) st_n = S_CFG;
      S_CFG:  if (out_ready) st_n = S_WAIT;
      S_WAIT: begin
        if (ack_in) begin
          st_n  = (len_q == '0) ? S_REL : S_XFER;
          rem_n = len_q;
        end else if (expired) begin
          st_n = S_REL;
        end
      end
      S_XFER: begin
        rem_n = rem_q - LEN_W'(1);
        if (rem_q == LEN_W'(1)) st_n = S_REL;
      end
      S_REL:  if (out_ready) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_IDLE;
      dst_q       <= '0;
      len_q       <= '0;
      rem_q       <= '0;
      timed_out_q <= 1'b0;
      busy_q      <= 1'b0;
      valid_q     <= 1'b0;
      kind_q      <= PKT_CFG;
      en_q        <= 1'b0;
      last_q      <= 1'b0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
    end else begin
      st_q  <= st_n;
      rem_q <= rem_n;
      if (st_q == S_IDLE && req_valid) begin
        dst_q       <= req_dst;
        len_q       <= req_len;
        timed_out_q <= 1'b0;
      end
      if (st_q == S_WAIT && !ack_in && expired) timed_out_q <= 1'b1;
      busy_q  <= (st_n != S_IDLE);
      valid_q <= (st_n == S_CFG) || (st_n == S_REL);
      kind_q  <= (st_n == S_REL) ? PKT_REL : PKT_CFG;
      en_q    <= (st_n == S_XFER);
      last_q  <= (st_n == S_XFER) && (rem_n == LEN_W'(1));
      done_q  <= (st_q == S_REL) && (st_n == S_IDLE) && !timed_out_q;
      fail_q  <= (st_q == S_REL) && (st_n == S_IDLE) && timed_out_q;
    end
  end

  assign busy       = busy_q;
  assign out_valid  = valid_q;
  assign out_kind   = kind_q;
  assign out_dst    = dst_q;
  assign data_en    = en_q;
  assign data_last  = last_q;
  assign done_pulse = done_q;
  assign fail_pulse = fail_q;

  // R4: payload starts only on the edge that sampled an acknowledge
  a_r4_payload_after_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> $past(ack_in));

  // R6: no payload while a control packet is offered
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(en_q && valid_q));

  // R3: destination held constant for the whole circuit
  a_r3_dst_stable: assert property (@(posedge clk) disable iff (rst)
    busy_q && $past(busy_q) |-> $stable(dst_q));

  // R2: an unaccepted packet stays offered with the same kind
  a_r2_pkt_held: assert property (@(posedge clk) disable iff (rst)
    valid_q && !out_ready |=> valid_q && $stable(kind_q));

  // R7: success and failure never reported together
  a_r7_excl_result: assert property (@(posedge clk) disable iff (rst)
    !(done_q && fail_q));

  // R4: last marker only on a payload word
  a_r4_last_in_payload: assert property (@(posedge clk) disable iff (rst)
    last_q |-> en_q);

endmodule

// File: rtl/cls_dst_resp.sv
module cls_dst_resp
  import cls_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_kind,
  input  logic [ADDR_W-1:0] in_src,
  output logic              ack_out,
  output logic              held,
  output logic [ADDR_W-1:0] peer
);
  logic              held_q, ack_q;
  logic [ADDR_W-1:0] peer_q;
  logic              take_cfg, take_rel;

  assign take_cfg = in_valid && (in_kind == PKT_CFG) && !held_q;
  assign take_rel = in_valid && (in_kind == PKT_REL) && held_q && (in_src == peer_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      ack_q  <= 1'b0;
      peer_q <= '0;
    end else begin
      ack_q <= take_cfg;
      if (take_cfg) begin
        held_q <= 1'b1;
        peer_q <= in_src;
      end else if (take_rel) begin
        held_q <= 1'b0;
      end
    end
  end

  assign ack_out = ack_q;
  assign held    = held_q;
  assign peer    = peer_q;

  // R9: acknowledge is exactly one cycle wide
  a_r9_ack_one_wide: assert property (@(posedge clk) disable iff (rst)
    ack_q |=> !ack_q);

  // R9: a fresh hold is always acknowledged
  a_r9_hold_acked: assert property (@(posedge clk) disable iff (rst)
    $rose(held_q) |-> ack_q);

  // R10: owner does not change while held
  a_r10_peer_stable: assert property (@(posedge clk) disable iff (rst)
    held_q && $past(held_q) |-> $stable(peer_q));

endmodule

// File: rtl/circuit_link_ctrl.sv
module circuit_link_ctrl #(
  parameter int NODE_ID = 0,
  parameter int ADDR_W  = 6,
  parameter int LEN_W   = 8,
  parameter int TO_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_dst,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [TO_W-1:0]   timeout_cycles,
  output logic              busy,
  output logic              done_pulse,
  output logic              fail_pulse,
  output logic              ctl_out_valid,
  input  logic              ctl_out_ready,
  output logic              ctl_out_kind,
  output logic [ADDR_W-1:0] ctl_out_dst,
  output logic [ADDR_W-1:0] ctl_out_src,
  input  logic              ack_in,
  output logic              data_en,
  output logic              data_last,
  input  logic              ctl_in_valid,
  input  logic              ctl_in_kind,
  input  logic [ADDR_W-1:0] ctl_in_src,
  output logic              ack_out,
  output logic              dst_held,
  output logic [ADDR_W-1:0] dst_peer
);
  localparam logic [ADDR_W-1:0] SELF = ADDR_W'(NODE_ID);

  assign ctl_out_src = SELF;

  cls_src_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TO_W(TO_W)) u_src (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_dst        (req_dst),
    .req_len        (req_len),
    .timeout_cycles (timeout_cycles),
    .out_ready      (ctl_out_ready),
    .ack_in         (ack_in),
    .busy           (busy),
    .done_pulse     (done_pulse),
    .fail_pulse     (fail_pulse),
    .out_valid      (ctl_out_valid),
    .out_kind       (ctl_out_kind),
    .out_dst        (ctl_out_dst),
    .data_en        (data_en),
    .data_last      (data_last)
  );

  cls_dst_resp #(.ADDR_W(ADDR_W)) u_dst (
    .clk      (clk),
    .rst      (rst),
    .in_valid (ctl_in_valid),
    .in_kind  (ctl_in_kind),
    .in_src   (ctl_in_src),
    .ack_out  (ack_out),
    .held     (dst_held),
    .peer     (dst_peer)
  );

endmodule

// File: tb/circuit_link_ctrl_tb.sv
`timescale 1ns/1ps
module circuit_link_ctrl_tb;
  localparam int AW = 6, LW = 8, TW = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0; logic [AW-1:0] req_dst = '0; logic [LW-1:0] req_len = '0;
  logic [TW-1:0] timeout_cycles = '0;
  logic busy, done_pulse, fail_pulse, ctl_out_valid, ctl_out_kind, data_en, data_last;
  logic ctl_out_ready = 0, ack_in = 0;
  logic [AW-1:0] ctl_out_dst, ctl_out_src, dst_peer;
  logic ctl_in_valid = 0, ctl_in_kind = 0; logic [AW-1:0] ctl_in_src = '0;
  logic ack_out, dst_held;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  circuit_link_ctrl #(.NODE_ID(9), .ADDR_W(AW), .LEN_W(LW), .TO_W(TW)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // use_ack: raise ack after sample number ack_at; extra: second ack during payload
  task automatic xfer(input int dst, input int len, input int ack_at, input bit use_ack,
                      input int tmo, input int rd, input bit extra);
    int low = 0, en = 0, last = 0, last_at = -1;
    timeout_cycles = TW'(tmo);
    req_dst = AW'(dst); req_len = LW'(len); req_valid = 1;
    @(negedge clk); req_valid = 0;
    chk(busy == 1, "R2 busy", busy, 1);
    chk(ctl_out_valid == 1 && ctl_out_kind == 0, "R2 cfg kind", ctl_out_kind, 0);
    chk(ctl_out_dst == AW'(dst), "R2 cfg dst", ctl_out_dst, dst);
    for (int i = 0; i < rd; i++) begin
      req_valid = 1; req_dst = AW'(dst ^ 1); req_len = LW'(7);
      @(negedge clk); req_valid = 0;
      chk(ctl_out_valid == 1 && ctl_out_kind == 0, "R2 cfg blocked", ctl_out_valid, 1);
    end
    ctl_out_ready = 1; @(negedge clk); ctl_out_ready = 0;
    for (int k = 0; k < 400; k++) begin
      if (ctl_out_valid) break;
      low++;
      if (data_en) en++;
      if (data_last) begin last++; last_at = en; end
      ack_in = use_ack && ((low == ack_at) || (extra && low == ack_at + 1));
      @(negedge clk);
    end
    ack_in = 0;
    if (use_ack) begin
      chk(en == len, "R4 word count", en, len);
      chk(last == (len > 0 ? 1 : 0), "R4 last count", last, len > 0 ? 1 : 0);
      if (len > 0) chk(last_at == len, "R4 last position", last_at, len);
      else chk(en == 0, "R5 no payload", en, 0);
      chk(low == ack_at + len, "R6 release timing", low, ack_at + len);
    end else begin
      chk(en == 0, "R7 no payload", en, 0);
      chk(low == (tmo < 1 ? 1 : tmo), "R7 expiry cycles", low, tmo < 1 ? 1 : tmo);
    end
    chk(ctl_out_kind == 1, "R6 release kind", ctl_out_kind, 1);
    chk(ctl_out_dst == AW'(dst), "R3 release dst", ctl_out_dst, dst);
    for (int i = 0; i < rd; i++) begin
      @(negedge clk);
      chk(ctl_out_valid == 1 && busy == 1, "R6 release blocked", ctl_out_valid, 1);
    end
    ctl_out_ready = 1; @(negedge clk); ctl_out_ready = 0;
    chk(busy == 0 && ctl_out_valid == 0, "R6 busy drop", busy, 0);
    if (use_ack) chk(done_pulse == 1 && fail_pulse == 0, "R6 done", done_pulse, 1);
    else         chk(fail_pulse == 1 && done_pulse == 0, "R7 fail", fail_pulse, 1);
    @(negedge clk);
    chk(done_pulse == 0 && fail_pulse == 0, "R6 pulse width", done_pulse | fail_pulse, 0);
  endtask

  task automatic dpkt(input bit kind, input int src, input bit exp_ack,
                      input bit exp_held, input int exp_peer, input string req);
    ctl_in_valid = 1; ctl_in_kind = kind; ctl_in_src = AW'(src);
    @(negedge clk); ctl_in_valid = 0;
    chk(ack_out == exp_ack, req, ack_out, exp_ack);
    chk(dst_held == exp_held, req, dst_held, exp_held);
    if (exp_held) chk(dst_peer == AW'(exp_peer), req, dst_peer, exp_peer);
    @(negedge clk);
    chk(ack_out == 0, "R9 ack width", ack_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && ctl_out_valid == 0 && data_en == 0 && data_last == 0, "R1 src idle", busy, 0);
    chk(done_pulse == 0 && fail_pulse == 0, "R1 pulses", done_pulse, 0);
    chk(dst_held == 0 && ack_out == 0, "R1 dst free", dst_held, 0);
    // R4 R5 R6: sweep of length, acknowledge delay and stall
    for (int len = 0; len <= 4; len++)
      for (int a = 1; a <= 3; a++)
        xfer(len * 5 + a, len, a, 1'b1, 8, (len + a) % 3, (len > 1));
    // R7: acknowledge never arrives
    for (int t = 0; t <= 5; t++) xfer(40 + t, 3, 0, 1'b0, t, t % 2, 1'b0);
    // R8: acknowledge in the expiry cycle
    for (int t = 1; t <= 4; t++) xfer(50 + t, 2, t, 1'b1, t, 1, 1'b0);
    // R9 R10 R11: destination side
    dpkt(1'b1, 4, 0, 0, 0, "R11 release when free");
    dpkt(1'b0, 3, 1, 1, 3, "R9 cfg taken");
    dpkt(1'b0, 5, 0, 1, 3, "R10 cfg ignored");
    dpkt(1'b1, 5, 0, 1, 3, "R11 foreign release");
    dpkt(1'b1, 3, 0, 0, 0, "R11 owner release");
    dpkt(1'b0, 7, 1, 1, 7, "R9 cfg again");
    dpkt(1'b1, 7, 0, 0, 0, "R11 owner release 2");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule